// File: doc/BRIEF.md
# Switch Input Debounce Filter

This block cleans up the level coming from a mechanical pushbutton or toggle switch. When such a contact is actuated it chatters for a few milliseconds before it settles. The filter turns that chatter into a single clean level change on its output. The raw level is sampled by two flip-flops in series. A run-length counter measures how many clocks those two samples have agreed. Only a run that reaches a configured length moves the sampled level into the output register.

The run length comes from two elaboration-time parameters: the system clock rate in hertz and the required quiet time in milliseconds. A second variant can be chosen instead. It sets the run length to a power of two and takes the end-of-interval signal straight from the counter's top bit, so no full-width compare is needed. An active-low asynchronous reset clears the whole datapath.

Top module: `switch_debounce`

## Requirements
- R1: While `rst_n` is low, `sw_clean` is 0. The reset acts at once, without waiting for a clock edge.
- R2: With `CARRY_BITS` = 0 the run length T in clocks is `CLK_HZ * STABLE_MS / 1000`, with a minimum of 1. At the defaults T is 500,000.
- R3: Suppose `sw_raw` holds a value v at T+1 consecutive rising edges, counted from the first edge that samples v. Then `sw_clean` equals v after the (T+3)-th of those edges.
- R4: A value of `sw_raw` that lasts for T sampled edges or fewer never appears on `sw_clean`.
- R5: The run-length counter saturates at T and never wraps. The output therefore stays fixed for as long as the input is held, however long that is.
- R6: With `CARRY_BITS` = N > 0 the run length is T = 2^N. The end of the interval is signalled by the counter's top bit.
- R7: After reset is released, `sw_clean` stays 0 until the input has completed a full run of T+1 equal samples.
- R8: A single differing sample in the middle of a run clears the counter. The new level must then complete a whole fresh interval before the output can follow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_raw | input | 1 | Raw, possibly bouncing switch level |
| sw_clean | output | 1 | Debounced level |

## Verification
The two sample registers and the counter are the block's only hidden state, and any fault in them shows up as a change in the timing of `sw_clean`. A counter that clears too late, wraps, or compares against the wrong limit makes the output move on the wrong edge: too early after a burst, or some cycles away from the T+3 edge point. A bench model that tracks the run length of the input catches that difference within the interval where it occurs. A sample register that is skipped or duplicated shifts every output change by one edge, and so it appears on the very first clean transition.

// File: rtl/sw_debounce_pkg.sv
package sw_debounce_pkg;

  // Run length in clocks: derived from clock rate and quiet time, or a
  // power of two when the carry-out variant is selected.
  function automatic int unsigned hold_cycles(input longint unsigned clk_hz,
                                              input longint unsigned stable_ms,
                                              input int unsigned     carry_bits);
    longint unsigned t;
    if (carry_bits != 0) t = longint'(1) << carry_bits;
    else                 t = (clk_hz * stable_ms) / 1000;
    if (t == 0) t = 1;
    return t[31:0];
  endfunction

  // Smallest width that can represent the value limit.
  function automatic int unsigned count_width(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((longint'(1) << w) <= longint'(limit)) w++;
    return w;
  endfunction

endpackage

// File: rtl/sw_sampler.sv
module sw_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic near_q,
  output logic far_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      near_q <= 1'b0;
      far_q  <= 1'b0;
    end else begin
      near_q <= raw;
      far_q  <= near_q;
    end
  end
endmodule

// File: rtl/sw_run_counter.sv
module sw_run_counter #(
  parameter int unsigned LIMIT      = 16,
  parameter int unsigned WIDTH      = 5,
  parameter int unsigned CARRY_BITS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             differ,
  output logic [WIDTH-1:0] count,
  output logic             full
);
  localparam logic [WIDTH-1:0] LIMIT_W = WIDTH'(LIMIT);

  generate
    if (CARRY_BITS != 0) begin : g_carry
      // Limit is 2^N and width N+1, so the top bit is the carry-out.
      assign full = count[WIDTH-1];
    end else begin : g_compare
      assign full = (count == LIMIT_W);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (differ) count <= '0;
    else if (!full)  count <= count + 1'b1;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT_W);
endmodule

// File: rtl/sw_out_reg.sv
module sw_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/switch_debounce.sv
module switch_debounce #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned STABLE_MS  = 10,
  parameter int unsigned CARRY_BITS = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_raw,
  output logic sw_clean
);
  import sw_debounce_pkg::*;

  localparam int unsigned LIMIT = hold_cycles(CLK_HZ, STABLE_MS, CARRY_BITS);
  localparam int unsigned WIDTH = count_width(LIMIT);
  localparam logic [WIDTH-1:0] LIMIT_W = WIDTH'(LIMIT);

  logic             samp_near;
  logic             samp_far;
  logic             samples_differ;
  logic [WIDTH-1:0] run_count;
  logic             run_full;

  sw_sampler u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (sw_raw),
    .near_q (samp_near),
    .far_q  (samp_far)
  );

  assign samples_differ = samp_near ^ samp_far;

  sw_run_counter #(
    .LIMIT      (LIMIT),
    .WIDTH      (WIDTH),
    .CARRY_BITS (CARRY_BITS)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .differ (samples_differ),
    .count  (run_count),
    .full   (run_full)
  );

  sw_out_reg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (run_full),
    .d     (samp_far),
    .q     (sw_clean)
  );

  // R8: a sample mismatch restarts the run
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_near != samp_far) |=> (run_count == '0));

  // R3: a completed run moves the older sample to the output
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_count == LIMIT_W) |=> (sw_clean == $past(samp_far)));

  // R4: no completed run, no output change
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_count != LIMIT_W) |=> $stable(sw_clean));

  // R6 / R2: end-of-interval flag agrees with the counter value
  assert_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_full |-> (run_count == LIMIT_W));
endmodule

// File: tb/switch_debounce_test.sv
module switch_debounce_test;
  localparam int HZ_A = 8000;
  localparam int MS_A = 2;
  localparam int NB_B = 3;

  function automatic int run_len_ms(input int hz, input int ms);
    return (hz / 1000) * ms;
  endfunction
  function automatic int run_len_pow(input int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 2;
    return r;
  endfunction
  function automatic int next_run(input bit d, input bit prev, input int run);
    if (d != prev) return 1;
    return (run > 1000000) ? run : run + 1;
  endfunction

  localparam int TA = run_len_ms(HZ_A, MS_A);
  localparam int TB = run_len_pow(NB_B);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic qa, qb;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  switch_debounce #(.CLK_HZ(HZ_A), .STABLE_MS(MS_A), .CARRY_BITS(0)) uut (
    .clk(clk), .rst_n(rst_n), .sw_raw(din), .sw_clean(qa));
  switch_debounce #(.CLK_HZ(1000), .STABLE_MS(1), .CARRY_BITS(NB_B)) uut_pow (
    .clk(clk), .rst_n(rst_n), .sw_raw(din), .sw_clean(qb));

  // reference: run length of equal samples, output follows two edges later
  bit d1, d2, ea, eb;
  int r1, r2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 = 0; d2 = 0; r1 = 2; r2 = 1; ea = 0; eb = 0;
    end else begin
      int rn;
      rn = next_run(din, d1, r1);
      if (r2 >= TA + 1) ea = d2;
      if (r2 >= TB + 1) eb = d2;
      d2 = d1; d1 = din; r2 = r1; r1 = rn;
    end
  end

  string tag = "R1";

  task automatic check(input bit act, input bit exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(qa, ea, tag, "compare-time output");
    check(qb, eb, (tag == "R2") ? "R6" : tag, "power-of-two output");
  end

  task automatic hold(input bit v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din = v;
    end
  endtask

  task automatic measure(input int exp_a, input int exp_b);
    bit sa, sb, goal;
    int na, nb, n;
    goal = ~qa; sa = 0; sb = 0; na = 0; nb = 0; n = 0;
    din = goal;
    while (!(sa && sb) && n < 200) begin
      @(negedge clk);
      n++;
      if (!sa && qa == goal) begin sa = 1; na = n; end
      if (!sb && qb == goal) begin sb = 1; nb = n; end
    end
    total++;
    if (na != exp_a) begin bad++; $display("FAIL R2 latency: actual=%0d expected=%0d", na, exp_a); end
    total++;
    if (nb != exp_b) begin bad++; $display("FAIL R6 latency: actual=%0d expected=%0d", nb, exp_b); end
  endtask

  task automatic finish_up;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    tag = "R1";
    din = 1'b1;
    repeat (3) @(negedge clk);
    check(qa, 1'b0, "R1", "in reset");
    // R7: input high across reset release must still wait a full run
    tag = "R7";
    rst_n = 1'b1;
    hold(1'b1, TA + 10);
    tag = "R2";
    hold(1'b1, 20);
    measure(TA + 3, TB + 3);      // R3 latency for the compare variant
    hold(qa, 20);
    tag = "R3";
    measure(TA + 3, TB + 3);
    hold(qa, 20);
    // R4: bursts no longer than the run length
    tag = "R4";
    for (int k = 0; k < 40; k++) begin
      hold(~din, 1 + ($urandom % TB));
    end
    // R8: mid-run glitch restarts the interval
    tag = "R8";
    hold(~qa, TA - 2);
    hold(qa, 1);
    hold(~qa, TA + 6);
    hold(din, 10);
    // R5: long hold, beyond counter wrap distance
    tag = "R5";
    hold(din, 300);
    check(qa, din, "R5", "after long hold");
    // mixed random runs
    tag = "R3";
    for (int k = 0; k < 120; k++) begin
      bit v;
      v = 1'($urandom);
      if (($urandom % 3) == 0) hold(v, 1 + ($urandom % (TA + 1)));
      else                     hold(v, TA + 1 + ($urandom % (2 * TA)));
    end
    hold(1'b1, 3 * TA);
    // R1: asynchronous clear, checked between edges
    @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    done = 1;
    total++;
    if (qa !== 1'b0 || qb !== 1'b0) begin
      bad++;
      $display("FAIL R1 async clear: actual=%0b%0b expected=00", qa, qb);
    end
    finish_up();
  end
endmodule